// File: doc/BRIEF.md
# Pipeline Operand Bypass and Load Interlock Unit

This unit settles the data hazards of a five-stage pipeline (fetch, decode, execute, memory, write-back) in which branch operands are compared in decode. Each cycle it looks at the source register numbers held in decode and in execute. It compares them with the destination numbers and write enables of the execute, memory and write-back stages. From that comparison it picks, for every operand, where the value should come from.

It drives four operand selects. Two feed the execute-stage ALU inputs. The other two feed the decode-stage operand path, which serves both the branch comparator and the values captured into the decode/execute register. The decode path also covers the case where a register is written in write-back in the same cycle it is read. When a value cannot be bypassed in time, the unit raises a one-cycle stall. The stall freezes the program counter and the fetch/decode register and inserts a bubble into the decode/execute register. This happens for a load followed directly by its consumer, and for a branch whose operand is still being computed or loaded.

The unit is purely combinational. The datapath multiplexers, the register file and the branch target logic sit outside it. Instructions after a branch are never flushed by this unit, because the slot after a branch always executes.

Top module: `hazard_fwd_unit`

## Requirements
- R1: An execute-stage source that matches the nonzero destination of a register-writing, non-load instruction in memory gets select 2'b01.
- R2: An execute-stage source that matches only the nonzero destination of a register-writing instruction in write-back gets select 2'b10.
- R3: When memory and write-back both write the matching register, the memory stage wins (2'b01), for execute and decode selects alike.
- R4: A source numbered 0 always gets select 2'b00 and never causes a stall.
- R5: The decode selects follow the same rules as the execute selects. A write-back producer gives 2'b10, which makes a producer three instructions ahead visible in decode.
- R6: A load in execute that writes a nonzero register read by the decode instruction (per its read flags) raises the stall. When it does, hold and bubble are both 1, and outside a stall both are 0.
- R7: A non-branch instruction never stalls for an ALU producer in execute. No instruction stalls for a source it does not read.
- R8: A branch in decode stalls when any register-writing instruction in execute produces one of its read operands.
- R9: A branch in decode stalls when a load in memory produces one of its read operands. A non-load producer in memory is bypassed (2'b01) with no stall.
- R10: When the youngest matching producer is a load in memory, the select is 2'b00. The older write-back value is not bypassed.
- R11: With no matching producer, all selects are 2'b00 and there is no stall. The code 2'b11 never appears.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| id_rs | input | REG_W | First source register in decode |
| id_rt | input | REG_W | Second source register in decode |
| id_rs_rd | input | 1 | Decode instruction reads id_rs |
| id_rt_rd | input | 1 | Decode instruction reads id_rt |
| id_branch | input | 1 | Decode instruction compares operands for a branch |
| ex_rs | input | REG_W | First source register in execute |
| ex_rt | input | REG_W | Second source register in execute |
| ex_dst | input | REG_W | Destination register in execute |
| ex_wen | input | 1 | Execute instruction writes a register |
| ex_load | input | 1 | Execute instruction is a load |
| mem_dst | input | REG_W | Destination register in memory |
| mem_wen | input | 1 | Memory instruction writes a register |
| mem_load | input | 1 | Memory instruction is a load |
| wb_dst | input | REG_W | Destination register in write-back |
| wb_wen | input | 1 | Write-back instruction writes a register |
| ex_sel_a | output | 2 | Execute operand A source: 00 pipe, 01 memory, 10 write-back |
| ex_sel_b | output | 2 | Execute operand B source, same coding |
| id_sel_a | output | 2 | Decode operand A source, same coding |
| id_sel_b | output | 2 | Decode operand B source, same coding |
| stall_hold | output | 1 | Hold program counter and fetch/decode register |
| stall_bubble | output | 1 | Load a no-op into the decode/execute register |

## Verification
The assertions assume that every input is a known value. They are evaluated only when that holds. They also assume that a memory-stage load never meets a matching execute consumer, since the stall prevents that pairing in a real pipeline. The stimulus honours this by giving execute-stage sources either no match against a memory-stage load or a register chosen so that the load-match case is checked only as a select value. The stimulus is applied on the falling clock edge, so every input is settled before any check is made.

// File: rtl/hazard_fwd_unit.sv
module hazard_fwd_unit #(
  parameter int REG_W = 5
) (
  input  logic [REG_W-1:0] id_rs,
  input  logic [REG_W-1:0] id_rt,
  input  logic             id_rs_rd,
  input  logic             id_rt_rd,
  input  logic             id_branch,
  input  logic [REG_W-1:0] ex_rs,
  input  logic [REG_W-1:0] ex_rt,
  input  logic [REG_W-1:0] ex_dst,
  input  logic             ex_wen,
  input  logic             ex_load,
  input  logic [REG_W-1:0] mem_dst,
  input  logic             mem_wen,
  input  logic             mem_load,
  input  logic [REG_W-1:0] wb_dst,
  input  logic             wb_wen,
  output logic [1:0]       ex_sel_a,
  output logic [1:0]       ex_sel_b,
  output logic [1:0]       id_sel_a,
  output logic [1:0]       id_sel_b,
  output logic             stall_hold,
  output logic             stall_bubble
);
  localparam logic [1:0] SEL_PIPE = 2'b00;
  localparam logic [1:0] SEL_MEM  = 2'b01;
  localparam logic [1:0] SEL_WB   = 2'b10;

  function automatic logic [1:0] pick_src(input logic [REG_W-1:0] src,
                                          input logic [REG_W-1:0] m_dst,
                                          input logic             m_wen,
                                          input logic             m_ld,
                                          input logic [REG_W-1:0] w_dst,
                                          input logic             w_wen);
    if (src == '0)                    return SEL_PIPE;
    if (m_wen && m_dst == src)        return m_ld ? SEL_PIPE : SEL_MEM;
    if (w_wen && w_dst == src)        return SEL_WB;
    return SEL_PIPE;
  endfunction

  assign ex_sel_a = pick_src(ex_rs, mem_dst, mem_wen, mem_load, wb_dst, wb_wen);
  assign ex_sel_b = pick_src(ex_rt, mem_dst, mem_wen, mem_load, wb_dst, wb_wen);
  assign id_sel_a = pick_src(id_rs, mem_dst, mem_wen, mem_load, wb_dst, wb_wen);
  assign id_sel_b = pick_src(id_rt, mem_dst, mem_wen, mem_load, wb_dst, wb_wen);

  logic ex_live, mem_ld_live, ex_needed, mem_needed, stall;

  assign ex_live     = ex_wen && (ex_dst != '0);
  assign mem_ld_live = mem_wen && mem_load && (mem_dst != '0);
  assign ex_needed   = (id_rs_rd && id_rs == ex_dst) || (id_rt_rd && id_rt == ex_dst);
  assign mem_needed  = (id_rs_rd && id_rs == mem_dst) || (id_rt_rd && id_rt == mem_dst);

  assign stall = (ex_live && ex_needed && (ex_load || id_branch))
               || (id_branch && mem_ld_live && mem_needed);

  assign stall_hold   = stall;
  assign stall_bubble = stall;
endmodule

module hazard_fwd_chk #(
  parameter int REG_W = 5
) (
  input logic [REG_W-1:0] id_rs,
  input logic [REG_W-1:0] id_rt,
  input logic             id_rs_rd,
  input logic             id_rt_rd,
  input logic             id_branch,
  input logic [REG_W-1:0] ex_rs,
  input logic [REG_W-1:0] ex_rt,
  input logic [REG_W-1:0] ex_dst,
  input logic             ex_wen,
  input logic             ex_load,
  input logic [REG_W-1:0] mem_dst,
  input logic             mem_wen,
  input logic             mem_load,
  input logic [REG_W-1:0] wb_dst,
  input logic             wb_wen,
  input logic [1:0]       ex_sel_a,
  input logic [1:0]       ex_sel_b,
  input logic [1:0]       id_sel_a,
  input logic [1:0]       id_sel_b,
  input logic             stall_hold,
  input logic             stall_bubble
);
  logic known;
  assign known = !$isunknown({id_rs, id_rt, id_rs_rd, id_rt_rd, id_branch, ex_rs, ex_rt,
                              ex_dst, ex_wen, ex_load, mem_dst, mem_wen, mem_load,
                              wb_dst, wb_wen, ex_sel_a, ex_sel_b, id_sel_a, id_sel_b,
                              stall_hold, stall_bubble});

  always_comb begin
    if (known) begin
      a_r11_no_code3: assert (ex_sel_a != 2'b11 && ex_sel_b != 2'b11 &&
                              id_sel_a != 2'b11 && id_sel_b != 2'b11)
        else $error("select code 11 driven");
      a_r4_zero_src: assert ((ex_rs != '0 || ex_sel_a == 2'b00) && (ex_rt != '0 || ex_sel_b == 2'b00) &&
                             (id_rs != '0 || id_sel_a == 2'b00) && (id_rt != '0 || id_sel_b == 2'b00))
        else $error("register 0 bypassed");
      a_r6_hold_bubble: assert (stall_hold == stall_bubble)
        else $error("hold and bubble disagree");
      a_r6_load_use: assert (!(ex_wen && ex_load && ex_dst != '0 && id_rs_rd && id_rs == ex_dst) || stall_hold)
        else $error("load-use without stall");
      a_r7_alu_no_stall: assert (id_branch || ex_load || !stall_hold)
        else $error("non-branch stalled on non-load");
      a_r2_wb_path: assert (!(ex_rs != '0 && wb_wen && wb_dst == ex_rs && !(mem_wen && mem_dst == ex_rs))
                            || ex_sel_a == 2'b10)
        else $error("write-back bypass missed");
      a_r10_mem_load: assert (!(ex_rs != '0 && mem_wen && mem_load && mem_dst == ex_rs) || ex_sel_a == 2'b00)
        else $error("memory load bypassed early");
    end
  end
endmodule

bind hazard_fwd_unit hazard_fwd_chk #(.REG_W(REG_W)) i_chk (
  .id_rs(id_rs), .id_rt(id_rt), .id_rs_rd(id_rs_rd), .id_rt_rd(id_rt_rd), .id_branch(id_branch),
  .ex_rs(ex_rs), .ex_rt(ex_rt), .ex_dst(ex_dst), .ex_wen(ex_wen), .ex_load(ex_load),
  .mem_dst(mem_dst), .mem_wen(mem_wen), .mem_load(mem_load), .wb_dst(wb_dst), .wb_wen(wb_wen),
  .ex_sel_a(ex_sel_a), .ex_sel_b(ex_sel_b), .id_sel_a(id_sel_a), .id_sel_b(id_sel_b),
  .stall_hold(stall_hold), .stall_bubble(stall_bubble)
);

// File: tb/test_hazard_fwd_unit.sv
module test_hazard_fwd_unit;
  logic clk = 1'b0;
  always #5 clk = ~clk;

  logic [4:0] id_rs, id_rt, ex_rs, ex_rt, ex_dst, mem_dst, wb_dst;
  logic id_rs_rd, id_rt_rd, id_branch, ex_wen, ex_load, mem_wen, mem_load, wb_wen;
  logic [1:0] ex_sel_a, ex_sel_b, id_sel_a, id_sel_b;
  logic stall_hold, stall_bubble;

  hazard_fwd_unit #(.REG_W(5)) i_hazard_fwd_unit (
    .id_rs(id_rs), .id_rt(id_rt), .id_rs_rd(id_rs_rd), .id_rt_rd(id_rt_rd), .id_branch(id_branch),
    .ex_rs(ex_rs), .ex_rt(ex_rt), .ex_dst(ex_dst), .ex_wen(ex_wen), .ex_load(ex_load),
    .mem_dst(mem_dst), .mem_wen(mem_wen), .mem_load(mem_load), .wb_dst(wb_dst), .wb_wen(wb_wen),
    .ex_sel_a(ex_sel_a), .ex_sel_b(ex_sel_b), .id_sel_a(id_sel_a), .id_sel_b(id_sel_b),
    .stall_hold(stall_hold), .stall_bubble(stall_bubble)
  );

  typedef struct packed {
    logic [4:0] irs, irt; logic rsr, rtr, br;
    logic [4:0] ers, ert, edst; logic ewen, eld;
    logic [4:0] mdst; logic mwen, mld;
    logic [4:0] wdst; logic wwen;
    logic [1:0] xa, xb, ia, ib; logic st;
    logic [31:0] tag;
  } vec_t;

  localparam int NV = 20;
  localparam vec_t VECS [NV] = '{
    '{5'd1, 5'd2, 1'b1,1'b1,1'b0, 5'd3, 5'd4, 5'd0, 1'b0,1'b0, 5'd3, 1'b1,1'b0, 5'd0, 1'b0, 2'd1,2'd0,2'd0,2'd0,1'b0, "R1  "},
    '{5'd1, 5'd2, 1'b1,1'b1,1'b0, 5'd8, 5'd7, 5'd0, 1'b0,1'b0, 5'd7, 1'b1,1'b0, 5'd0, 1'b0, 2'd0,2'd1,2'd0,2'd0,1'b0, "R1  "},
    '{5'd1, 5'd2, 1'b1,1'b1,1'b0, 5'd5, 5'd6, 5'd0, 1'b0,1'b0, 5'd0, 1'b0,1'b0, 5'd6, 1'b1, 2'd0,2'd2,2'd0,2'd0,1'b0, "R2  "},
    '{5'd1, 5'd2, 1'b1,1'b1,1'b0, 5'd9, 5'd9, 5'd0, 1'b0,1'b0, 5'd0, 1'b0,1'b0, 5'd9, 1'b1, 2'd2,2'd2,2'd0,2'd0,1'b0, "R2  "},
    '{5'd1, 5'd2, 1'b1,1'b1,1'b0, 5'd10,5'd11,5'd0, 1'b0,1'b0, 5'd10,1'b1,1'b0, 5'd10,1'b1, 2'd1,2'd0,2'd0,2'd0,1'b0, "R3  "},
    '{5'd1, 5'd2, 1'b1,1'b1,1'b0, 5'd12,5'd12,5'd0, 1'b0,1'b0, 5'd12,1'b1,1'b0, 5'd12,1'b1, 2'd1,2'd1,2'd0,2'd0,1'b0, "R3  "},
    '{5'd0, 5'd0, 1'b1,1'b1,1'b1, 5'd0, 5'd0, 5'd0, 1'b1,1'b1, 5'd0, 1'b1,1'b0, 5'd0, 1'b1, 2'd0,2'd0,2'd0,2'd0,1'b0, "R4  "},
    '{5'd13,5'd14,1'b1,1'b1,1'b0, 5'd0, 5'd0, 5'd0, 1'b0,1'b0, 5'd13,1'b1,1'b0, 5'd14,1'b1, 2'd0,2'd0,2'd1,2'd2,1'b0, "R5  "},
    '{5'd15,5'd16,1'b1,1'b1,1'b1, 5'd0, 5'd0, 5'd0, 1'b0,1'b0, 5'd0, 1'b0,1'b0, 5'd16,1'b1, 2'd0,2'd0,2'd0,2'd2,1'b0, "R5  "},
    '{5'd17,5'd2, 1'b1,1'b1,1'b0, 5'd0, 5'd0, 5'd17,1'b1,1'b1, 5'd0, 1'b0,1'b0, 5'd0, 1'b0, 2'd0,2'd0,2'd0,2'd0,1'b1, "R6  "},
    '{5'd3, 5'd18,1'b1,1'b1,1'b0, 5'd0, 5'd0, 5'd18,1'b1,1'b1, 5'd0, 1'b0,1'b0, 5'd0, 1'b0, 2'd0,2'd0,2'd0,2'd0,1'b1, "R6  "},
    '{5'd19,5'd2, 1'b1,1'b1,1'b0, 5'd0, 5'd0, 5'd19,1'b1,1'b0, 5'd0, 1'b0,1'b0, 5'd0, 1'b0, 2'd0,2'd0,2'd0,2'd0,1'b0, "R7  "},
    '{5'd20,5'd21,1'b0,1'b1,1'b0, 5'd0, 5'd0, 5'd20,1'b1,1'b1, 5'd0, 1'b0,1'b0, 5'd0, 1'b0, 2'd0,2'd0,2'd0,2'd0,1'b0, "R7  "},
    '{5'd22,5'd2, 1'b1,1'b1,1'b1, 5'd0, 5'd0, 5'd22,1'b1,1'b0, 5'd0, 1'b0,1'b0, 5'd0, 1'b0, 2'd0,2'd0,2'd0,2'd0,1'b1, "R8  "},
    '{5'd1, 5'd23,1'b1,1'b1,1'b1, 5'd0, 5'd0, 5'd23,1'b1,1'b1, 5'd0, 1'b0,1'b0, 5'd0, 1'b0, 2'd0,2'd0,2'd0,2'd0,1'b1, "R8  "},
    '{5'd24,5'd2, 1'b1,1'b1,1'b1, 5'd0, 5'd0, 5'd0, 1'b0,1'b0, 5'd24,1'b1,1'b1, 5'd0, 1'b0, 2'd0,2'd0,2'd0,2'd0,1'b1, "R9  "},
    '{5'd25,5'd2, 1'b1,1'b1,1'b1, 5'd0, 5'd0, 5'd0, 1'b0,1'b0, 5'd25,1'b1,1'b0, 5'd0, 1'b0, 2'd0,2'd0,2'd1,2'd0,1'b0, "R9  "},
    '{5'd26,5'd2, 1'b1,1'b1,1'b0, 5'd26,5'd0, 5'd0, 1'b0,1'b0, 5'd26,1'b1,1'b1, 5'd26,1'b1, 2'd0,2'd0,2'd0,2'd0,1'b0, "R10 "},
    '{5'd1, 5'd2, 1'b1,1'b1,1'b1, 5'd3, 5'd4, 5'd5, 1'b1,1'b0, 5'd6, 1'b1,1'b0, 5'd7, 1'b1, 2'd0,2'd0,2'd0,2'd0,1'b0, "R11 "},
    '{5'd27,5'd2, 1'b1,1'b1,1'b0, 5'd0, 5'd0, 5'd0, 1'b0,1'b0, 5'd27,1'b1,1'b0, 5'd27,1'b1, 2'd0,2'd0,2'd1,2'd0,1'b0, "R3  "}
  };

  int n_run = 0, n_fail = 0;
  bit finished = 1'b0;

  task automatic drive(input vec_t v);
    @(negedge clk);
    id_rs = v.irs; id_rt = v.irt; id_rs_rd = v.rsr; id_rt_rd = v.rtr; id_branch = v.br;
    ex_rs = v.ers; ex_rt = v.ert; ex_dst = v.edst; ex_wen = v.ewen; ex_load = v.eld;
    mem_dst = v.mdst; mem_wen = v.mwen; mem_load = v.mld; wb_dst = v.wdst; wb_wen = v.wwen;
    #1;
  endtask

  task automatic check(input vec_t v);
    n_run++;
    if ({ex_sel_a, ex_sel_b, id_sel_a, id_sel_b, stall_hold, stall_bubble} !=
        {v.xa, v.xb, v.ia, v.ib, v.st, v.st}) begin
      n_fail++;
      $display("FAIL %s: got xa=%0d xb=%0d ia=%0d ib=%0d hold=%0d bubble=%0d, expected xa=%0d xb=%0d ia=%0d ib=%0d hold=%0d bubble=%0d",
               v.tag, ex_sel_a, ex_sel_b, id_sel_a, id_sel_b, stall_hold, stall_bubble,
               v.xa, v.xb, v.ia, v.ib, v.st, v.st);
    end
  endtask

  initial begin
    vec_t v;
    v = '0;
    v.tag = "R11 ";
    drive(v);
    check(v);  // R11: idle pipeline gives all-zero outputs

    for (int i = 0; i < NV; i++) begin
      drive(VECS[i]);
      check(VECS[i]);
    end

    for (int r = 0; r < 32; r++) begin  // R1 and R4 swept over every register
      v = '0;
      v.ers = 5'(r); v.ert = 5'(r); v.irs = 5'(r); v.rsr = 1'b1;
      v.mdst = 5'(r); v.mwen = 1'b1;
      v.xa = (r == 0) ? 2'd0 : 2'd1;
      v.xb = v.xa; v.ia = v.xa;
      v.tag = (r == 0) ? "R4  " : "R1  ";
      drive(v);
      check(v);
    end

    for (int r = 1; r < 32; r++) begin  // R6: load-use on every register, then cleared
      v = '0;
      v.irt = 5'(r); v.rtr = 1'b1; v.edst = 5'(r); v.ewen = 1'b1; v.eld = 1'b1;
      v.st = 1'b1; v.tag = "R6  ";
      drive(v);
      check(v);
      v.ewen = 1'b0; v.st = 1'b0; v.tag = "R7  ";
      drive(v);
      check(v);
    end

    finished = 1'b1;
    $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
    $finish;
  end

  initial begin
    #(200000 * 10);
    if (!finished) begin
      n_run++;
      n_fail++;
      $display("FAIL watchdog: got timeout, expected completion");
      $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
      $finish;
    end
  end
endmodule